// File: doc/BRIEF.md
# Per-Processor Interrupt Presentation Stage

This block sits between a set of interrupt source controllers and one processor. It keeps a 32-bit pending word. The word holds the processor's current priority and the number of the one request that is latched for delivery. The block also keeps the priority of that latched request and a separate priority for inter-processor interrupts (IPIs). A latched request drives the single interrupt line to the processor. The rule for priorities is that a numerically smaller value is more favoured, and 0xFF is fully masked.

Sources offer requests, each with a source number and a priority. The block latches a request that beats both the current priority and whatever is already latched. Anything it refuses or pushes out goes back to its source as a one-cycle notification. The processor drives one command per cycle: set current priority, set IPI priority, accept, end-of-interrupt, or poll. Priority changes and end-of-interrupt can ask every source to offer again through a resend pulse. When a command and a request arrive in the same cycle, the command acts first and the request is judged against the state the command leaves.

Top module: `cpu_irq_presenter`

## Requirements
- R1: After synchronous reset the pending word is zero, the latched priority and the IPI priority are 0xFF, the interrupt line is low and no notification pulses. A poll (op code 5) then returns word 0x00000000 and IPI priority 0xFF.
- R2: A request whose priority is greater than or equal to the current priority (word bits 31:24) is refused. Refusal is a one-cycle bounce pulse that carries the request's source number, and the pending word is left unchanged.
- R3: A request is also refused if a request is already latched with a priority less than or equal to the new one. Otherwise it is latched. Any previously latched source request is first evicted with a one-cycle evict pulse carrying its number. The word becomes {current priority, new source} and the line rises.
- R4: A latched IPI is displaced by a more favoured source request without any evict pulse.
- R5: Setting the IPI priority (op code 2, value in data bits 7:0) to a value below the current priority runs the IPI check. The check does nothing if a latched request's priority is less than or equal to the IPI priority. Otherwise it evicts any latched source request, loads source number 2 with the IPI priority, and raises the line.
- R6: Setting a more favoured current priority (op code 1, value in data bits 7:0) with a latched request whose priority is not below the new value clears the source field. It also sets the latched priority to 0xFF, lowers the line and evicts the request if it came from a source.
- R7: Setting an equal or less favoured current priority while nothing is latched performs a resend. A resend runs the IPI check if the IPI priority is below the current priority, then gives a one-cycle resend pulse. No resend happens while a request is latched.
- R8: Accept (op code 3) returns the pending word as it was before the command, with a response valid pulse, and lowers the line. The current priority then takes the latched priority, the source field clears and the latched priority becomes 0xFF.
- R9: End-of-interrupt (op code 4) copies data bits 31:24 into the current priority and pulses the end-of-interrupt notification with data bits 23:0. It performs a resend only if nothing is latched.
- R10: Poll (op code 5) returns the pending word and the IPI priority with a response valid pulse, and changes no state.
- R11: When a command and a request share a cycle, the request is evaluated against the state produced by the command.
- R12: The interrupt line is high exactly when the source field of the pending word is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Source request present this cycle |
| req_src | input | 24 | Requesting source number |
| req_prio | input | 8 | Requested priority |
| cmd_valid | input | 1 | Processor command present this cycle |
| cmd_op | input | 3 | Command op code (1..5) |
| cmd_data | input | 32 | Command operand |
| irq_out | output | 1 | Interrupt line to the processor |
| bounce_valid | output | 1 | Incoming request refused |
| bounce_src | output | 24 | Source number of the refused request |
| evict_valid | output | 1 | Previously latched request pushed back |
| evict_src | output | 24 | Source number of the evicted request |
| eoi_valid | output | 1 | End-of-interrupt notification |
| eoi_src | output | 24 | Source number being completed |
| resend_pulse | output | 1 | Ask all sources to offer again |
| rsp_valid | output | 1 | Response to accept or poll |
| rsp_word | output | 32 | Pending word returned |
| rsp_ipi | output | 8 | IPI priority returned |

## Verification
The properties assume that requests carry a nonzero source number different from the IPI number. They also assume inputs stay idle while reset is held, and that the command op is one of the five defined codes. The stimulus only uses source numbers of 0x10 and above, releases reset before driving anything, and issues only defined op codes. Checks that compare against pre-command state exclude cycles where a request shares the cycle with the command, because the request is then judged against the command's result.

// File: rtl/irqp_pkg.sv
package irqp_pkg;

    localparam int SRC_W  = 24;
    localparam int PRIO_W = 8;
    localparam int WORD_W = SRC_W + PRIO_W;

    typedef logic [SRC_W-1:0]  src_t;
    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [WORD_W-1:0] word_t;

    localparam prio_t PRIO_MASKED = '1;
    localparam src_t  SRC_NONE    = '0;

    typedef enum logic [2:0] {
        OP_NONE     = 3'd0,
        OP_SET_CUR  = 3'd1,
        OP_SET_IPI  = 3'd2,
        OP_ACCEPT   = 3'd3,
        OP_EOI      = 3'd4,
        OP_POLL     = 3'd5
    } op_e;

    // Architectural state of one presentation unit
    typedef struct packed {
        prio_t cur;    // current processor priority
        src_t  src;    // latched source number, zero when idle
        prio_t pend;   // priority of the latched request
        prio_t ipi;    // inter-processor request priority
        logic  owned;  // latched request came from a source
        logic  irq;    // line to the processor
    } pres_t;

    typedef struct packed {
        logic valid;
        src_t src;
    } note_t;

    typedef struct packed {
        pres_t st;
        note_t ev;
    } step_t;

    localparam pres_t PRES_RESET = '{
        cur:   '0,
        src:   SRC_NONE,
        pend:  PRIO_MASKED,
        ipi:   PRIO_MASKED,
        owned: 1'b0,
        irq:   1'b0
    };

    // IPI check: latch the IPI unless something at least as favoured waits
    function automatic step_t ipi_check(pres_t s, src_t ipi_id);
        step_t r;
        r.st = s;
        r.ev = '0;
        if (!((s.src != SRC_NONE) && (s.pend <= s.ipi))) begin
            if ((s.src != SRC_NONE) && s.owned) begin
                r.ev.valid = 1'b1;
                r.ev.src   = s.src;
            end
            r.st.src   = ipi_id;
            r.st.pend  = s.ipi;
            r.st.owned = 1'b0;
            r.st.irq   = 1'b1;
        end
        return r;
    endfunction

    // Resend: IPI check when its priority beats the current priority
    function automatic step_t resend_step(pres_t s, src_t ipi_id);
        step_t r;
        r.st = s;
        r.ev = '0;
        if (s.ipi < s.cur) begin
            r = ipi_check(s, ipi_id);
        end
        return r;
    endfunction

endpackage

// File: rtl/irqp_cmd_eval.sv
module irqp_cmd_eval
    import irqp_pkg::*;
(
    input  pres_t             st_i,
    input  src_t              ipi_src_i,
    input  logic              cmd_valid_i,
    input  logic [2:0]        cmd_op_i,
    input  logic [WORD_W-1:0] cmd_data_i,
    output pres_t             st_o,
    output note_t             evict_o,
    output note_t             eoi_o,
    output logic              resend_o,
    output logic              rsp_o
);

    prio_t new_prio;
    step_t t;

    assign new_prio = cmd_data_i[PRIO_W-1:0];

    always_comb begin
        st_o     = st_i;
        evict_o  = '0;
        eoi_o    = '0;
        resend_o = 1'b0;
        rsp_o    = 1'b0;
        t        = '0;
        if (cmd_valid_i) begin
            case (op_e'(cmd_op_i))
                OP_SET_CUR: begin
                    st_o.cur = new_prio;
                    if (new_prio < st_i.cur) begin
                        if ((st_i.src != SRC_NONE) && (new_prio <= st_i.pend)) begin
                            st_o.src   = SRC_NONE;
                            st_o.pend  = PRIO_MASKED;
                            st_o.irq   = 1'b0;
                            st_o.owned = 1'b0;
                            if (st_i.owned) begin
                                evict_o.valid = 1'b1;
                                evict_o.src   = st_i.src;
                            end
                        end
                    end else if (st_i.src == SRC_NONE) begin
                        t        = resend_step(st_o, ipi_src_i);
                        st_o     = t.st;
                        evict_o  = t.ev;
                        resend_o = 1'b1;
                    end
                end
                OP_SET_IPI: begin
                    st_o.ipi = new_prio;
                    if (new_prio < st_i.cur) begin
                        t       = ipi_check(st_o, ipi_src_i);
                        st_o    = t.st;
                        evict_o = t.ev;
                    end
                end
                OP_ACCEPT: begin
                    rsp_o      = 1'b1;
                    st_o.cur   = st_i.pend;
                    st_o.src   = SRC_NONE;
                    st_o.pend  = PRIO_MASKED;
                    st_o.owned = 1'b0;
                    st_o.irq   = 1'b0;
                end
                OP_EOI: begin
                    st_o.cur    = cmd_data_i[WORD_W-1:SRC_W];
                    eoi_o.valid = 1'b1;
                    eoi_o.src   = cmd_data_i[SRC_W-1:0];
                    if (st_i.src == SRC_NONE) begin
                        t        = resend_step(st_o, ipi_src_i);
                        st_o     = t.st;
                        evict_o  = t.ev;
                        resend_o = 1'b1;
                    end
                end
                OP_POLL: rsp_o = 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/irqp_req_eval.sv
module irqp_req_eval
    import irqp_pkg::*;
(
    input  pres_t st_i,
    input  logic  req_valid_i,
    input  src_t  req_src_i,
    input  prio_t req_prio_i,
    output pres_t st_o,
    output note_t bounce_o,
    output note_t evict_o
);

    logic refuse;

    assign refuse = (req_prio_i >= st_i.cur) ||
                    ((st_i.src != SRC_NONE) && (st_i.pend <= req_prio_i));

    always_comb begin
        st_o     = st_i;
        bounce_o = '0;
        evict_o  = '0;
        if (req_valid_i) begin
            if (refuse) begin
                bounce_o.valid = 1'b1;
                bounce_o.src   = req_src_i;
            end else begin
                if ((st_i.src != SRC_NONE) && st_i.owned) begin
                    evict_o.valid = 1'b1;
                    evict_o.src   = st_i.src;
                end
                st_o.src   = req_src_i;
                st_o.pend  = req_prio_i;
                st_o.owned = 1'b1;
                st_o.irq   = 1'b1;
            end
        end
    end

endmodule

// File: rtl/cpu_irq_presenter.sv
module cpu_irq_presenter
    import irqp_pkg::*;
#(
    parameter int unsigned IPI_SRC_ID = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [SRC_W-1:0]  req_src,
    input  logic [PRIO_W-1:0] req_prio,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [WORD_W-1:0] cmd_data,
    output logic              irq_out,
    output logic              bounce_valid,
    output logic [SRC_W-1:0]  bounce_src,
    output logic              evict_valid,
    output logic [SRC_W-1:0]  evict_src,
    output logic              eoi_valid,
    output logic [SRC_W-1:0]  eoi_src,
    output logic              resend_pulse,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_word,
    output logic [PRIO_W-1:0] rsp_ipi
);

    localparam src_t IPI_SRC = src_t'(IPI_SRC_ID);

    pres_t st_q, st_cmd, st_req;
    note_t cmd_evict, req_evict, req_bounce, cmd_eoi;
    logic  cmd_resend, cmd_rsp;
    note_t bounce_q, evict_q, eoi_q;
    logic  resend_q, rsp_valid_q;
    word_t rsp_word_q;
    prio_t rsp_ipi_q;

    // Views of the held state for the bound checker
    prio_t cur_view, ipi_view;
    src_t  src_view;
    logic  cmd_ev_view, req_ev_view;

    irqp_cmd_eval u_cmd (
        .st_i        (st_q),
        .ipi_src_i   (IPI_SRC),
        .cmd_valid_i (cmd_valid),
        .cmd_op_i    (cmd_op),
        .cmd_data_i  (cmd_data),
        .st_o        (st_cmd),
        .evict_o     (cmd_evict),
        .eoi_o       (cmd_eoi),
        .resend_o    (cmd_resend),
        .rsp_o       (cmd_rsp)
    );

    // Request is judged against the state the command leaves
    irqp_req_eval u_req (
        .st_i        (st_cmd),
        .req_valid_i (req_valid),
        .req_src_i   (req_src),
        .req_prio_i  (req_prio),
        .st_o        (st_req),
        .bounce_o    (req_bounce),
        .evict_o     (req_evict)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= PRES_RESET;
            bounce_q    <= '0;
            evict_q     <= '0;
            eoi_q       <= '0;
            resend_q    <= 1'b0;
            rsp_valid_q <= 1'b0;
            rsp_word_q  <= '0;
            rsp_ipi_q   <= PRIO_MASKED;
        end else begin
            st_q        <= st_req;
            bounce_q    <= req_bounce;
            evict_q     <= cmd_evict.valid ? cmd_evict : req_evict;
            eoi_q       <= cmd_eoi;
            resend_q    <= cmd_resend;
            rsp_valid_q <= cmd_rsp;
            if (cmd_rsp) begin
                rsp_word_q <= {st_q.cur, st_q.src};
                rsp_ipi_q  <= st_q.ipi;
            end
        end
    end

    assign irq_out      = st_q.irq;
    assign bounce_valid = bounce_q.valid;
    assign bounce_src   = bounce_q.src;
    assign evict_valid  = evict_q.valid;
    assign evict_src    = evict_q.src;
    assign eoi_valid    = eoi_q.valid;
    assign eoi_src      = eoi_q.src;
    assign resend_pulse = resend_q;
    assign rsp_valid    = rsp_valid_q;
    assign rsp_word     = rsp_word_q;
    assign rsp_ipi      = rsp_ipi_q;

    assign cur_view    = st_q.cur;
    assign ipi_view    = st_q.ipi;
    assign src_view    = st_q.src;
    assign cmd_ev_view = cmd_evict.valid;
    assign req_ev_view = req_evict.valid;

endmodule

// File: rtl/irqp_checker.sv
module irqp_checker
    import irqp_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input prio_t      req_prio,
    input logic       cmd_valid,
    input logic [2:0] cmd_op,
    input logic       irq_out,
    input logic       bounce_valid,
    input logic       evict_valid,
    input logic       eoi_valid,
    input logic       resend_pulse,
    input logic       rsp_valid,
    input prio_t      cur_prio,
    input src_t       pend_src,
    input prio_t      ipi_prio,
    input logic       cmd_ev,
    input logic       req_ev
);

    // R1
    reset_values_chk: assert property (@(posedge clk)
        $past(rst) |-> (!irq_out && pend_src == SRC_NONE && ipi_prio == PRIO_MASKED));

    // R12
    line_tracks_src_chk: assert property (@(posedge clk) disable iff (rst)
        irq_out == (pend_src != SRC_NONE));

    // R2
    low_prio_bounce_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !cmd_valid && req_prio >= cur_prio) |=> bounce_valid);

    // R3
    single_evict_chk: assert property (@(posedge clk) disable iff (rst)
        !(cmd_ev && req_ev));

    // R8
    accept_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_ACCEPT && !req_valid) |=> (!irq_out && pend_src == SRC_NONE));

    // R8
    rsp_origin_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(cmd_valid && (cmd_op == OP_ACCEPT || cmd_op == OP_POLL)));

    // R9
    eoi_origin_chk: assert property (@(posedge clk) disable iff (rst)
        eoi_valid |-> $past(cmd_valid && cmd_op == OP_EOI));

    // R10
    poll_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_POLL && !req_valid) |=>
            ($stable(cur_prio) && $stable(pend_src) && !evict_valid && !resend_pulse));

endmodule

bind cpu_irq_presenter irqp_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_prio     (req_prio),
    .cmd_valid    (cmd_valid),
    .cmd_op       (cmd_op),
    .irq_out      (irq_out),
    .bounce_valid (bounce_valid),
    .evict_valid  (evict_valid),
    .eoi_valid    (eoi_valid),
    .resend_pulse (resend_pulse),
    .rsp_valid    (rsp_valid),
    .cur_prio     (cur_view),
    .pend_src     (src_view),
    .ipi_prio     (ipi_view),
    .cmd_ev       (cmd_ev_view),
    .req_ev       (req_ev_view)
);

// File: tb/cpu_irq_presenter_test.sv
module cpu_irq_presenter_test;
    import irqp_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [23:0] req_src = '0;
    logic [7:0]  req_prio = '0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [31:0] cmd_data = '0;
    logic        irq_out, bounce_valid, evict_valid, eoi_valid, resend_pulse, rsp_valid;
    logic [23:0] bounce_src, evict_src, eoi_src;
    logic [31:0] rsp_word;
    logic [7:0]  rsp_ipi;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    cpu_irq_presenter uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_src(req_src), .req_prio(req_prio),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
        .irq_out(irq_out),
        .bounce_valid(bounce_valid), .bounce_src(bounce_src),
        .evict_valid(evict_valid), .evict_src(evict_src),
        .eoi_valid(eoi_valid), .eoi_src(eoi_src),
        .resend_pulse(resend_pulse),
        .rsp_valid(rsp_valid), .rsp_word(rsp_word), .rsp_ipi(rsp_ipi)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] want);
        n_cmp++;
        if (act !== want) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, want);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        req_valid = 1'b0;
        cmd_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Drive for one cycle; outputs are sampled at the following falling edge
    task automatic issue(input logic cv, input logic [2:0] op, input logic [31:0] d,
                         input logic rv, input logic [23:0] s, input logic [7:0] p);
        @(negedge clk);
        cmd_valid = cv; cmd_op = op; cmd_data = d;
        req_valid = rv; req_src = s; req_prio = p;
        @(negedge clk);
        cmd_valid = 1'b0;
        req_valid = 1'b0;
    endtask

    task automatic cmd(input logic [2:0] op, input logic [31:0] d);
        issue(1'b1, op, d, 1'b0, '0, '0);
    endtask

    task automatic req(input logic [23:0] s, input logic [7:0] p);
        issue(1'b0, 3'd0, '0, 1'b1, s, p);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1 reset state
        do_reset();
        chk("R1 line", irq_out, 0);
        chk("R1 pulses", {bounce_valid, evict_valid, eoi_valid, resend_pulse}, 0);
        cmd(OP_POLL, 0);
        chk("R1 rsp valid", rsp_valid, 1);
        chk("R1 word", rsp_word, 32'h0);
        chk("R1 ipi", rsp_ipi, 32'hFF);
        req(24'h10, 8'h00);
        chk("R2 bounce at zero priority", bounce_valid, 1);

        // R2 / R3 sweep of request priority against current priority 8
        for (int p = 0; p < 16; p++) begin
            do_reset();
            cmd(OP_SET_CUR, 32'h8);
            req(24'(32'h100 + p), 8'(p));
            chk("R2 bounce", bounce_valid, (p >= 8));
            if (p >= 8) chk("R2 bounce src", bounce_src, 32'h100 + p);
            chk("R3 line", irq_out, (p < 8));
            cmd(OP_POLL, 0);
            chk("R3 word", rsp_word, (p < 8) ? (32'h08000100 + p) : 32'h08000000);
        end

        // R3 displacement sweep against latched priority 5
        for (int q = 0; q < 8; q++) begin
            do_reset();
            cmd(OP_SET_CUR, 32'h8);
            req(24'h10, 8'h5);
            req(24'h20, 8'(q));
            chk("R3 evict", evict_valid, (q < 5));
            if (q < 5) chk("R3 evict src", evict_src, 32'h10);
            chk("R3 refuse", bounce_valid, (q >= 5));
            cmd(OP_POLL, 0);
            chk("R3 word after", rsp_word, (q < 5) ? 32'h08000020 : 32'h08000010);
        end

        // R5 IPI priority sweep with nothing latched
        for (int m = 0; m < 16; m++) begin
            do_reset();
            cmd(OP_SET_CUR, 32'h8);
            cmd(OP_SET_IPI, 32'(m));
            chk("R5 line", irq_out, (m < 8));
            cmd(OP_POLL, 0);
            chk("R5 word", rsp_word, (m < 8) ? 32'h08000002 : 32'h08000000);
            chk("R5 ipi", rsp_ipi, 32'(m));
        end

        // R5 IPI against a latched source request at priority 4
        for (int m = 0; m < 8; m++) begin
            do_reset();
            cmd(OP_SET_CUR, 32'h8);
            req(24'h30, 8'h4);
            cmd(OP_SET_IPI, 32'(m));
            chk("R5 evict", evict_valid, (m < 4));
            if (m < 4) chk("R5 evict src", evict_src, 32'h30);
            cmd(OP_POLL, 0);
            chk("R5 word latched", rsp_word, (m < 4) ? 32'h08000002 : 32'h08000030);
        end

        // R4 IPI displaced silently
        do_reset();
        cmd(OP_SET_CUR, 32'h8);
        cmd(OP_SET_IPI, 32'h6);
        req(24'h44, 8'h2);
        chk("R4 no evict", evict_valid, 0);
        chk("R4 no bounce", bounce_valid, 0);
        cmd(OP_POLL, 0);
        chk("R4 word", rsp_word, 32'h08000044);

        // R6 more favoured current priority
        do_reset();
        cmd(OP_SET_CUR, 32'h8);
        req(24'h40, 8'h5);
        cmd(OP_SET_CUR, 32'h6);
        chk("R6 keep evict", evict_valid, 0);
        chk("R6 keep line", irq_out, 1);
        cmd(OP_SET_CUR, 32'h5);
        chk("R6 clear evict", evict_valid, 1);
        chk("R6 clear src", evict_src, 32'h40);
        chk("R6 clear line", irq_out, 0);
        cmd(OP_POLL, 0);
        chk("R6 word", rsp_word, 32'h05000000);

        // R7 resend on relaxing priority
        do_reset();
        cmd(OP_SET_CUR, 32'h4);
        chk("R7 resend idle", resend_pulse, 1);
        cmd(OP_SET_IPI, 32'h6);
        chk("R7 ipi held", irq_out, 0);
        cmd(OP_SET_CUR, 32'h8);
        chk("R7 resend", resend_pulse, 1);
        chk("R7 ipi line", irq_out, 1);
        cmd(OP_POLL, 0);
        chk("R7 word", rsp_word, 32'h08000002);
        do_reset();
        cmd(OP_SET_CUR, 32'h8);
        req(24'h12, 8'h3);
        cmd(OP_SET_CUR, 32'h9);
        chk("R7 no resend when latched", resend_pulse, 0);

        // R8 accept
        do_reset();
        cmd(OP_SET_CUR, 32'h8);
        req(24'h55, 8'h3);
        cmd(OP_ACCEPT, 0);
        chk("R8 rsp valid", rsp_valid, 1);
        chk("R8 word", rsp_word, 32'h08000055);
        chk("R8 line", irq_out, 0);
        cmd(OP_POLL, 0);
        chk("R8 after", rsp_word, 32'h03000000);

        // R9 end-of-interrupt
        cmd(OP_EOI, 32'h08000055);
        chk("R9 eoi", eoi_valid, 1);
        chk("R9 eoi src", eoi_src, 32'h55);
        chk("R9 resend", resend_pulse, 1);
        cmd(OP_POLL, 0);
        chk("R9 word", rsp_word, 32'h08000000);
        req(24'h77, 8'h2);
        cmd(OP_EOI, 32'h08000011);
        chk("R9 eoi src 2", eoi_src, 32'h11);
        chk("R9 no resend", resend_pulse, 0);
        chk("R9 line kept", irq_out, 1);

        // R10 poll has no effect
        cmd(OP_POLL, 0);
        cmd(OP_POLL, 0);
        chk("R10 word", rsp_word, 32'h08000077);
        chk("R10 ipi", rsp_ipi, 32'hFF);
        chk("R10 quiet", {evict_valid, resend_pulse, eoi_valid}, 0);
        chk("R10 line", irq_out, 1);

        // R11 command first, then request
        issue(1'b1, OP_SET_CUR, 32'h1, 1'b1, 24'h66, 8'h3);
        chk("R11 evict", evict_valid, 1);
        chk("R11 evict src", evict_src, 32'h77);
        chk("R11 bounce", bounce_valid, 1);
        chk("R11 bounce src", bounce_src, 32'h66);
        chk("R12 line low", irq_out, 0);
        do_reset();
        cmd(OP_SET_CUR, 32'h8);
        issue(1'b1, OP_ACCEPT, 0, 1'b1, 24'h21, 8'h2);
        chk("R11 accept word", rsp_word, 32'h08000000);
        chk("R12 line high", irq_out, 1);
        cmd(OP_POLL, 0);
        chk("R11 word", rsp_word, 32'hFF000021);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule